// File: doc/BRIEF.md
# Monochrome Color-Expansion Blit Engine

This block draws a rectangle of 8-bit palette-index pixels into a byte-addressed frame buffer. Its source is a 1-bit-per-pixel bitmap that the host streams in as 64-bit words. Each source bit is turned into a color: a 1 gives the foreground index and a 0 gives the background index. That color is then combined with the destination pixel under an 8-bit ternary raster-operation code. The result is written back at `y*pitch + x` bytes past the start address.

When write masking is enabled, the source bitmap also serves as a per-pixel mask. Pixels with a 0 bit are then neither read nor written. The engine works out from the raster code alone whether the destination must be read. It also reports whether the pattern operand would be needed, and it never fetches a pattern.

There are two streaming interfaces. The source port is valid/ready: the host holds `src_valid` and `src_data` steady until `src_ready` accepts the word. The engine raises `src_ready` only while it waits for a word. The frame-buffer request port is also valid/ready: once the engine raises `fb_valid`, it holds the address, the write flag and the write data until `fb_ready`. The engine keeps at most one read outstanding. The read data returns in a later cycle on `fb_rvalid`, which the engine always accepts. The start, busy, done and configuration pins are plain signals.

Top module: `mono_blit`

## Requirements
- R1: After reset, `busy`, `done`, `src_ready` and `fb_valid` are all 0.
- R2: A `start` pulse while idle captures every configuration input. If `width` or `height` is zero, `done` pulses without any source word taken and without any frame-buffer request.
- R3: Source bytes are taken from each 64-bit word lowest byte first (bits 7:0 first). Within a byte, bit 7 is the left-most pixel. Every scan line begins on a new byte, and the unused trailing bits of a line's last byte are skipped. Exactly ceil(ceil(width/8)*height/8) words are consumed, and the rest of the final word is discarded.
- R4: A source bit of 1 selects `fg_color[7:0]` and a bit of 0 selects `bg_color[7:0]`. Bits 23:8 of both color inputs have no effect.
- R5: Pixels are visited left to right within a line, and lines top to bottom. Pixel (x,y) is addressed at `dst_base + y*dst_pitch + x`, with the address width truncating.
- R6: Result bit k equals `rop[{P[k],S[k],D[k]}]`, with the pattern operand P taken as 0x00, S the expanded color and D the destination byte. Code 0xCC writes S unchanged.
- R7: When `mask_en` is 1, a pixel whose source bit is 0 gets no read and no write.
- R8: The destination is read (a request with `fb_we`=0 at the pixel's address, just before its write) only if the code depends on D, that is rop[7]≠rop[6], rop[5]≠rop[4], rop[3]≠rop[2] or rop[1]≠rop[0], and only if the pixel is not masked.
- R9: While busy, `pat_needed` is 1 exactly when rop[7:4]≠rop[3:0]. The engine never issues a frame-buffer request for a pattern.
- R10: A stalled `fb_valid` request keeps its address, write flag and data until accepted. `src_ready` is high only while busy and no source bit is left.
- R11: `done` is a one-cycle pulse in the cycle after the last pixel is written or skipped, and `busy` falls with it. A `start` pulse or configuration change during an operation has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| dst_base | input | ADDR_W | Byte address of the top-left destination pixel |
| dst_pitch | input | PITCH_W | Bytes between the starts of adjacent scan lines |
| width | input | DIM_W | Pixels per line |
| height | input | DIM_W | Number of lines |
| fg_color | input | 24 | Color for source bit 1 (bits 7:0 used) |
| bg_color | input | 24 | Color for source bit 0 (bits 7:0 used) |
| rop | input | 8 | Ternary raster-operation code |
| mask_en | input | 1 | Suppress pixels whose source bit is 0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pat_needed | output | 1 | Code depends on the pattern operand |
| src_valid | input | 1 | Source word offered |
| src_ready | output | 1 | Engine accepts a source word |
| src_data | input | SRC_W | Monochrome source word |
| fb_valid | output | 1 | Frame-buffer request valid |
| fb_ready | input | 1 | Frame-buffer request accepted |
| fb_we | output | 1 | 1 = write, 0 = read |
| fb_addr | output | ADDR_W | Request byte address |
| fb_wdata | output | 8 | Write data |
| fb_rvalid | input | 1 | Read data returned |
| fb_rdata | input | 8 | Read data |

## Verification
The bench builds the engine with ADDR_W=12, DIM_W=7 and PITCH_W=8. A 4096-byte memory model then covers the whole address space, and the bench can compare every write of an operation against its own expected sequence. Widths up to 64 pixels make lines that cross byte and word boundaries and lines that fill a whole word. Random back-pressure on both ports and random read latencies exercise every stall state of the engine.

// File: rtl/mono_blit_pkg.sv
package mono_blit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PIX,
    ST_FETCH,
    ST_RDREQ,
    ST_RDWAIT,
    ST_WRREQ,
    ST_DONE
  } blit_state_e;

  // Ternary raster evaluation: code bit index is {pattern, source, dest}
  function automatic logic [7:0] rop_apply(input logic [7:0] code,
                                           input logic [7:0] p,
                                           input logic [7:0] s,
                                           input logic [7:0] d);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) begin
      r[k] = code[{p[k], s[k], d[k]}];
    end
    return r;
  endfunction

  // The destination matters when flipping D can change some output bit
  function automatic logic rop_needs_dst(input logic [7:0] code);
    return (code[7] != code[6]) || (code[5] != code[4]) ||
           (code[3] != code[2]) || (code[1] != code[0]);
  endfunction

  // The pattern matters when the P=1 half differs from the P=0 half
  function automatic logic rop_needs_pat(input logic [7:0] code);
    return code[7:4] != code[3:0];
  endfunction

endpackage

// File: rtl/mono_blit_srcbuf.sv
module mono_blit_srcbuf #(
  parameter int SRC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [SRC_W-1:0] load_data,
  input  logic             step,
  input  logic             line_end,
  output logic             full,
  output logic             cur_bit
);
  localparam int LANES  = SRC_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [SRC_W-1:0]  word_q;
  logic [LANE_W-1:0] lane_q;
  logic [2:0]        bit_q;
  logic              full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      lane_q <= '0;
      bit_q  <= '0;
      full_q <= 1'b0;
    end else if (clear) begin
      lane_q <= '0;
      bit_q  <= '0;
      full_q <= 1'b0;
    end else if (load) begin
      word_q <= load_data;
      full_q <= 1'b1;
    end else if (step) begin
      if (line_end || (&bit_q)) begin
        bit_q  <= '0;
        lane_q <= lane_q + 1'b1;
        if (&lane_q) full_q <= 1'b0;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign full    = full_q;
  // lane L occupies bits 8L+7..8L; pixel 0 of a lane is its bit 7
  assign cur_bit = word_q[{lane_q, ~bit_q}];

  AST_STEP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> full_q); // R3
  AST_LOAD_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !full_q); // R10

endmodule

// File: rtl/mono_blit_walker.sv
module mono_blit_walker #(
  parameter int ADDR_W  = 23,
  parameter int DIM_W   = 12,
  parameter int PITCH_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [ADDR_W-1:0]  base,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [DIM_W-1:0]   width,
  input  logic [DIM_W-1:0]   height,
  input  logic               step,
  output logic [ADDR_W-1:0]  addr,
  output logic               last_x,
  output logic               last_pix
);
  logic [DIM_W-1:0]  x_q, y_q;
  logic [ADDR_W-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      line_q <= '0;
    end else if (clear) begin
      x_q    <= '0;
      y_q    <= '0;
      line_q <= base;
    end else if (step) begin
      if (last_x) begin
        x_q    <= '0;
        y_q    <= y_q + 1'b1;
        line_q <= line_q + ADDR_W'(pitch);
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  assign last_x   = (x_q == width - DIM_W'(1));
  assign last_pix = last_x && (y_q == height - DIM_W'(1));
  assign addr     = line_q + ADDR_W'(x_q);

  AST_X_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (x_q < width) && (y_q < height)); // R5

endmodule

// File: rtl/mono_blit_rop.sv
module mono_blit_rop
  import mono_blit_pkg::*;
#(
  parameter int COLOR_W = 24
) (
  input  logic [7:0]         code,
  input  logic [COLOR_W-1:0] fg,
  input  logic [COLOR_W-1:0] bg,
  input  logic               src_bit,
  input  logic [7:0]         dst,
  output logic [7:0]         result
);
  logic [7:0] expanded;
  logic       unused_hi;

  assign expanded  = src_bit ? fg[7:0] : bg[7:0];
  assign unused_hi = ^{fg[COLOR_W-1:8], bg[COLOR_W-1:8]};
  assign result    = rop_apply(code, 8'h00, expanded, dst);

endmodule

// File: rtl/mono_blit.sv
module mono_blit
  import mono_blit_pkg::*;
#(
  parameter int ADDR_W  = 23,
  parameter int DIM_W   = 12,
  parameter int PITCH_W = 13,
  parameter int SRC_W   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  dst_base,
  input  logic [PITCH_W-1:0] dst_pitch,
  input  logic [DIM_W-1:0]   width,
  input  logic [DIM_W-1:0]   height,
  input  logic [23:0]        fg_color,
  input  logic [23:0]        bg_color,
  input  logic [7:0]         rop,
  input  logic               mask_en,
  output logic               busy,
  output logic               done,
  output logic               pat_needed,
  input  logic               src_valid,
  output logic               src_ready,
  input  logic [SRC_W-1:0]   src_data,
  output logic               fb_valid,
  input  logic               fb_ready,
  output logic               fb_we,
  output logic [ADDR_W-1:0]  fb_addr,
  output logic [7:0]         fb_wdata,
  input  logic               fb_rvalid,
  input  logic [7:0]         fb_rdata
);
  localparam int COLOR_W = 24;

  blit_state_e state_q;

  logic [PITCH_W-1:0] pitch_q;
  logic [DIM_W-1:0]   width_q, height_q;
  logic [COLOR_W-1:0] fg_q, bg_q;
  logic [7:0]         rop_q, dst_q;
  logic               mask_q;

  logic kick, load, pix_adv;
  logic buf_full, cur_bit, last_x, last_pix;
  logic skip, need_dst;

  assign kick     = (state_q == ST_IDLE) && start;
  assign load     = (state_q == ST_FETCH) && src_valid;
  assign skip     = mask_q && !cur_bit;
  assign need_dst = rop_needs_dst(rop_q);
  assign pix_adv  = ((state_q == ST_PIX) && buf_full && skip) ||
                    ((state_q == ST_WRREQ) && fb_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pitch_q  <= '0;
      width_q  <= '0;
      height_q <= '0;
      fg_q     <= '0;
      bg_q     <= '0;
      rop_q    <= '0;
      mask_q   <= 1'b0;
      dst_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          pitch_q  <= dst_pitch;
          width_q  <= width;
          height_q <= height;
          fg_q     <= fg_color;
          bg_q     <= bg_color;
          rop_q    <= rop;
          mask_q   <= mask_en;
          state_q  <= (width == '0 || height == '0) ? ST_DONE : ST_PIX;
        end
        ST_PIX: begin
          if (!buf_full)     state_q <= ST_FETCH;
          else if (skip)     state_q <= last_pix ? ST_DONE : ST_PIX;
          else if (need_dst) state_q <= ST_RDREQ;
          else               state_q <= ST_WRREQ;
        end
        ST_FETCH:  if (src_valid) state_q <= ST_PIX;
        ST_RDREQ:  if (fb_ready)  state_q <= ST_RDWAIT;
        ST_RDWAIT: if (fb_rvalid) begin
          dst_q   <= fb_rdata;
          state_q <= ST_WRREQ;
        end
        ST_WRREQ:  if (fb_ready) state_q <= last_pix ? ST_DONE : ST_PIX;
        ST_DONE:   state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  mono_blit_srcbuf #(.SRC_W(SRC_W)) u_srcbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (kick),
    .load      (load),
    .load_data (src_data),
    .step      (pix_adv),
    .line_end  (last_x),
    .full      (buf_full),
    .cur_bit   (cur_bit)
  );

  mono_blit_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PITCH_W(PITCH_W)) u_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (kick),
    .base     (dst_base),
    .pitch    (pitch_q),
    .width    (width_q),
    .height   (height_q),
    .step     (pix_adv),
    .addr     (fb_addr),
    .last_x   (last_x),
    .last_pix (last_pix)
  );

  mono_blit_rop #(.COLOR_W(COLOR_W)) u_rop (
    .code    (rop_q),
    .fg      (fg_q),
    .bg      (bg_q),
    .src_bit (cur_bit),
    .dst     (dst_q),
    .result  (fb_wdata)
  );

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign pat_needed = rop_needs_pat(rop_q);
  assign src_ready  = (state_q == ST_FETCH);
  assign fb_valid   = (state_q == ST_RDREQ) || (state_q == ST_WRREQ);
  assign fb_we      = (state_q == ST_WRREQ);

  AST_FB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid && !fb_ready |=> fb_valid && $stable(fb_addr) && $stable(fb_we) && $stable(fb_wdata)); // R10
  AST_SRC_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> busy && !buf_full); // R10
  AST_MASK_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid && mask_q |-> cur_bit); // R7
  AST_READ_NEEDS_DST: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid && !fb_we |-> rop_needs_dst(rop_q)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R11

endmodule

// File: tb/mono_blit_bench.sv
`timescale 1ns/1ps
module mono_blit_bench;
  localparam int ADDR_W  = 12;
  localparam int DIM_W   = 7;
  localparam int PITCH_W = 8;
  localparam int SRC_W   = 64;
  localparam int MEM_N   = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic               start = 1'b0;
  logic [ADDR_W-1:0]  dst_base = '0;
  logic [PITCH_W-1:0] dst_pitch = '0;
  logic [DIM_W-1:0]   width = '0, height = '0;
  logic [23:0]        fg_color = '0, bg_color = '0;
  logic [7:0]         rop = '0;
  logic               mask_en = 1'b0;
  logic               busy, done, pat_needed;
  logic               src_valid = 1'b0;
  logic               src_ready;
  logic [SRC_W-1:0]   src_data = '0;
  logic               fb_valid, fb_we;
  logic               fb_ready = 1'b0;
  logic [ADDR_W-1:0]  fb_addr;
  logic [7:0]         fb_wdata;
  logic               fb_rvalid = 1'b0;
  logic [7:0]         fb_rdata = '0;

  mono_blit #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PITCH_W(PITCH_W), .SRC_W(SRC_W)) u_mono_blit (
    .clk(clk), .rst_n(rst_n), .start(start), .dst_base(dst_base), .dst_pitch(dst_pitch),
    .width(width), .height(height), .fg_color(fg_color), .bg_color(bg_color), .rop(rop),
    .mask_en(mask_en), .busy(busy), .done(done), .pat_needed(pat_needed),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .fb_valid(fb_valid), .fb_ready(fb_ready), .fb_we(fb_we), .fb_addr(fb_addr),
    .fb_wdata(fb_wdata), .fb_rvalid(fb_rvalid), .fb_rdata(fb_rdata)
  );

  int n_checks = 0;
  int n_fail = 0;

  logic [7:0]       mem [0:MEM_N-1];
  logic [SRC_W-1:0] src_mem [0:63];
  int exp_addr [0:1023];
  int exp_data [0:1023];
  int exp_n, exp_reads, exp_qw;
  int wr_idx, rd_cnt, src_idx, src_avail, rd_wait, rd_addr;
  logic src_take;
  logic need_d_bench;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Sum of minterms: each set code bit i enables the product selected by i
  function automatic logic [7:0] ref_rop(input logic [7:0] code, input logic [7:0] p,
                                         input logic [7:0] s, input logic [7:0] d);
    logic [7:0] acc = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (code[i])
        acc |= (i[2] ? p : ~p) & (i[1] ? s : ~s) & (i[0] ? d : ~d);
    end
    return acc;
  endfunction

  function automatic bit ref_dep_d(input logic [7:0] code);
    return ref_rop(code, 8'h00, 8'h00, 8'h00) != ref_rop(code, 8'h00, 8'h00, 8'hFF) ||
           ref_rop(code, 8'h00, 8'hFF, 8'h00) != ref_rop(code, 8'h00, 8'hFF, 8'hFF) ||
           ref_rop(code, 8'hFF, 8'h00, 8'h00) != ref_rop(code, 8'hFF, 8'h00, 8'hFF) ||
           ref_rop(code, 8'hFF, 8'hFF, 8'h00) != ref_rop(code, 8'hFF, 8'hFF, 8'hFF);
  endfunction

  // Source word responder
  initial begin
    forever begin
      @(negedge clk);
      if (src_take) begin
        src_idx++;
        src_valid = 1'b0;
        src_take = 1'b0;
      end
      if (!src_valid && src_idx < src_avail && ($urandom % 4) != 0) begin
        src_valid = 1'b1;
        src_data = src_mem[src_idx];
      end
      if (src_valid && src_ready) src_take = 1'b1;
    end
  end

  // Frame-buffer responder
  initial begin
    forever begin
      @(negedge clk);
      fb_rvalid = 1'b0;
      if (rd_wait > 0) begin
        rd_wait--;
        if (rd_wait == 0) begin
          fb_rvalid = 1'b1;
          fb_rdata = mem[rd_addr];
        end
      end
      fb_ready = ($urandom % 3) != 0;
      if (fb_valid && fb_ready) begin
        if (fb_we) begin
          if (wr_idx < exp_n) begin
            chk(fb_addr == exp_addr[wr_idx], "R5", "write address", fb_addr, exp_addr[wr_idx]);
            chk(fb_wdata == exp_data[wr_idx], "R4 R6", "write data", fb_wdata, exp_data[wr_idx]);
          end else begin
            chk(1'b0, "R7", "unexpected write", fb_addr, exp_n);
          end
          mem[fb_addr] = fb_wdata;
          wr_idx++;
        end else begin
          rd_cnt++;
          chk(need_d_bench && wr_idx < exp_n && fb_addr == exp_addr[wr_idx], "R8",
              "read address", fb_addr, (wr_idx < exp_n) ? exp_addr[wr_idx] : -1);
          rd_addr = fb_addr;
          rd_wait = 1 + ($urandom % 3);
        end
      end
    end
  end

  task automatic run_op(input int w, input int h, input logic [7:0] code, input logic msk,
                        input logic [23:0] fg, input logic [23:0] bg,
                        input int base, input int pitch, input bit poke);
    int bpl, cyc;
    @(posedge clk);
    #1;
    for (int i = 0; i < 64; i++) src_mem[i] = {$urandom, $urandom};
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'($urandom);
    need_d_bench = ref_dep_d(code);
    bpl = (w + 7) / 8;
    exp_n = 0;
    exp_reads = 0;
    exp_qw = (w == 0 || h == 0) ? 0 : (bpl * h + 7) / 8;
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        int bi;
        logic sb;
        logic [7:0] s, d;
        bi = y * bpl + x / 8;
        sb = src_mem[bi / 8][(bi % 8) * 8 + 7 - (x % 8)];
        if (msk && !sb) continue;
        s = sb ? fg[7:0] : bg[7:0];
        exp_addr[exp_n] = (base + y * pitch + x) % MEM_N;
        d = mem[exp_addr[exp_n]];
        exp_data[exp_n] = ref_rop(code, 8'h00, s, d);
        if (need_d_bench) exp_reads++;
        exp_n++;
      end
    end
    src_valid = 1'b0;
    src_take = 1'b0;
    src_idx = 0;
    src_avail = exp_qw + 1;
    wr_idx = 0;
    rd_cnt = 0;
    rd_wait = 0;
    dst_base = ADDR_W'(base);
    dst_pitch = PITCH_W'(pitch);
    width = DIM_W'(w);
    height = DIM_W'(h);
    fg_color = fg;
    bg_color = bg;
    rop = code;
    mask_en = msk;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk(pat_needed == (code[7:4] != code[3:0]), "R9", "pattern need", pat_needed,
        code[7:4] != code[3:0]);
    if (poke) begin
      // R11: a second start and new settings mid-operation must be ignored
      @(negedge clk);
      start = 1'b1;
      width = 7'd3;
      rop = 8'h00;
      fg_color = ~fg;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 20000, "R11", "done reached", cyc, 0);
    chk(wr_idx == exp_n, "R7", "write count", wr_idx, exp_n);
    chk(rd_cnt == exp_reads, "R8", "read count", rd_cnt, exp_reads);
    chk(src_idx + (src_take ? 1 : 0) == exp_qw, "R3", "words consumed",
        src_idx + (src_take ? 1 : 0), exp_qw);
    @(negedge clk);
    chk(!done && !busy && !src_ready && !fb_valid, "R11", "idle after done",
        {done, busy, src_ready, fb_valid}, 0);
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "R11", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'h5EED_1234);
    exp_n = 0;
    wr_idx = 0;
    rd_cnt = 0;
    src_idx = 0;
    src_avail = 0;
    rd_wait = 0;
    src_take = 1'b0;
    need_d_bench = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !src_ready && !fb_valid, "R1", "state in reset",
        {busy, done, src_ready, fb_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !src_ready && !fb_valid, "R1", "state after reset",
        {busy, done, src_ready, fb_valid}, 0);

    run_op(0, 3, 8'hCC, 1'b0, 24'h11_2233, 24'h44_5566, 10, 64, 1'b0);   // R2 zero width
    run_op(5, 0, 8'hCC, 1'b0, 24'h11_2233, 24'h44_5566, 10, 64, 1'b0);   // R2 zero height
    run_op(1, 1, 8'hCC, 1'b0, 24'hAB_CD12, 24'h98_7634, 32, 64, 1'b0);   // R6 copy
    run_op(13, 3, 8'hCC, 1'b1, 24'hFF_FF00, 24'h00_00EE, 5*64+7, 64, 1'b0); // R7 R3
    run_op(9, 4, 8'h66, 1'b0, 24'h00_005A, 24'h00_00C3, 200, 40, 1'b0);  // R8 xor
    run_op(10, 2, 8'hF0, 1'b0, 24'h00_0077, 24'h00_0011, 900, 50, 1'b0); // R9 pattern
    run_op(64, 2, 8'hCC, 1'b0, 24'h12_3456, 24'h65_4321, 100, 80, 1'b1); // R11 R3
    run_op(20, 3, 8'hAA, 1'b1, 24'h00_0001, 24'h00_0002, 4000, 255, 1'b0); // R5 wrap
    for (int t = 0; t < 10; t++) begin
      run_op(1 + ($urandom % 40), 1 + ($urandom % 6), 8'($urandom), 1'($urandom),
             24'($urandom), 24'($urandom), $urandom % 3000, 48 + ($urandom % 17), 1'b0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule